// File: doc/BRIEF.md
# Mailbox Command Responder

This block is the device-side end of a command mailbox on an I/O card, seen from a byte-wide host register bus. The host puts a 16-bit argument into two outgoing bytes and then writes a command byte. The block takes the command, waits a programmable processing delay, and then applies or fetches the addressed setting. It answers through an incoming mailbox: two feedback bytes, and then an echo byte that repeats the command code once the feedback is valid.

Because completion is shown only by the echo matching the command, the host must send the clear command (code 0x00) between two identical commands. The block also holds the relay output byte and a bank of 16-bit settings registers. It keeps a status byte of the isolated digital inputs, refreshed on a fixed period whether or not commands are running.

Top module: `mbx_responder`

## Requirements
- R1: After reset all four incoming bytes, the three readable outgoing bytes and the relay outputs read 0x00.
- R2: Byte offsets 0x0C (argument low), 0x0D (argument high) and 0x0E (command) read back the last value written. Writes to offset 0x0F are ignored, and it always reads 0x00.
- R3: A write to offset 0x0E while idle starts a command. The echo byte at offset 0x1E keeps its old value until exactly LAT_CYC+2 clock edges after the write edge, and then holds the command code.
- R4: The feedback bytes (low at 0x1C, high at 0x1D) take their new value one edge before the echo changes, and they do not change on the edge where the echo changes.
- R5: Command 0x00 sets the echo byte to 0x00 and returns zero feedback.
- R6: Command 0x01 loads the 8 relay outputs from the argument low byte and returns zero feedback. Command 0x02 returns the relay state in the low feedback byte and 0x00 in the high byte. The relays change only on command 0x01.
- R7: Commands SET_BASE to SET_BASE+SET_COUNT-1 (default 0x10 to 0x4F) store the 16-bit argument and return zero feedback. Command 0x03 returns the value stored for the code in its argument low byte. For code 0x01 it returns the relay byte, and for any other code it returns zero.
- R8: Command 0x0E returns the FW_VER parameter and command 0x0F returns the HW_VER parameter as 16-bit feedback.
- R9: Any other command code is still echoed and returns zero feedback.
- R10: The input status byte at offset 0x1F is loaded from the synchronised inputs once every REFRESH_CYC clock edges and changes at no other time.
- R11: A command write that arrives while a command is running is ignored (only stored for read-back). Argument writes made while a command is running do not alter that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host byte write strobe |
| bus_addr | input | ADDR_W | Host byte offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| din_raw | input | 8 | Isolated digital inputs, asynchronous |
| relay_o | output | 8 | Relay output states |

## Verification
The assertions take it for granted that the host writes the argument bytes before the command byte. They also assume the host waits for the echo before trusting the feedback, and that din_raw may change at any time. The bench follows that order in every table entry. It sends the clear command first whenever the next command equals the current echo, and it moves the inputs only on the falling edge. Exactly one directed case breaks the host rule on purpose: it writes a second command and new arguments while a command is running, to show that the running command is not altered.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam logic [7:0] CMD_CLEAR     = 8'h00;
   localparam logic [7:0] CMD_RELAY_SET = 8'h01;
   localparam logic [7:0] CMD_RELAY_GET = 8'h02;
   localparam logic [7:0] CMD_QUERY     = 8'h03;
   localparam logic [7:0] CMD_FW_VER    = 8'h0E;
   localparam logic [7:0] CMD_HW_VER    = 8'h0F;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_RUN  = 2'd1,
      ENG_ECHO = 2'd2
   } eng_state_t;

   typedef struct packed {
      logic [7:0]  code;
      logic [15:0] arg;
   } mbx_req_t;
endpackage

// File: rtl/mbx_input_sampler.sv
module mbx_input_sampler #(
   parameter int REFRESH_CYC = 5000,
   parameter int SYNC_STAGES = 2,
   parameter int WIDTH       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din_raw,
   output logic [WIDTH-1:0] status
);
   localparam int RC_W = $clog2(REFRESH_CYC + 1);

   logic [RC_W-1:0]  ref_cnt;
   logic             tick;
   logic [WIDTH-1:0] synced;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced = din_raw;
      end else begin : g_sync
         logic [WIDTH-1:0] chain [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) chain[s] <= '0;
            end else begin
               chain[0] <= din_raw;
               for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
            end
         end
         assign synced = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign tick = (ref_cnt == RC_W'(REFRESH_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_cnt <= '0;
         status  <= '0;
      end else begin
         ref_cnt <= tick ? '0 : ref_cnt + 1'b1;
         if (tick) status <= synced;
      end
   end

   // R10: status moves only on a refresh tick
   p_status_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (status != $past(status)) |-> $past(tick));
endmodule

// File: rtl/mbx_setting_bank.sv
module mbx_setting_bank
   import mbx_pkg::*;
#(
   parameter int SET_BASE  = 16,
   parameter int SET_COUNT = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_code,
   input  logic [15:0] wr_val,
   input  logic [7:0]  rd_code,
   output logic [15:0] rd_val,
   output logic [7:0]  relay
);
   logic [15:0] set_q [SET_COUNT];

   always_ff @(posedge clk) begin
      if (!rst_n) relay <= '0;
      else if (wr_en && wr_code == CMD_RELAY_SET) relay <= wr_val[7:0];
   end

   generate
      for (genvar i = 0; i < SET_COUNT; i++) begin : g_set
         always_ff @(posedge clk) begin
            if (!rst_n) set_q[i] <= '0;
            else if (wr_en && wr_code == 8'(SET_BASE + i)) set_q[i] <= wr_val;
         end
      end
   endgenerate

   always_comb begin
      rd_val = '0;
      if (rd_code == CMD_RELAY_SET) rd_val = {8'h00, relay};
      for (int i = 0; i < SET_COUNT; i++)
         if (rd_code == 8'(SET_BASE + i)) rd_val = set_q[i];
   end

   // R6: relays move only on a relay-set write
   p_relay_write_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (relay != $past(relay)) |-> ($past(wr_en) && $past(wr_code) == CMD_RELAY_SET));
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
   import mbx_pkg::*;
#(
   parameter int          LAT_CYC = 64,
   parameter logic [15:0] FW_VER  = 16'h0107,
   parameter logic [15:0] HW_VER  = 16'h0203
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  mbx_req_t    req,
   output logic        busy,
   output logic [15:0] fb,
   output logic [7:0]  echo,
   output logic        bank_we,
   output logic [7:0]  bank_code,
   output logic [15:0] bank_val,
   output logic [7:0]  rd_code,
   input  logic [15:0] rd_val,
   input  logic [7:0]  relay
);
   localparam int CNT_W = $clog2(LAT_CYC + 2);

   eng_state_t       state;
   mbx_req_t         cur;
   logic [CNT_W-1:0] cnt;
   logic             done;
   logic [15:0]      result;

   assign busy      = (state != ENG_IDLE);
   assign done      = (state == ENG_RUN) && (cnt == '0);
   assign bank_we   = done;
   assign bank_code = cur.code;
   assign bank_val  = cur.arg;
   assign rd_code   = cur.arg[7:0];

   always_comb begin
      case (cur.code)
         CMD_RELAY_GET: result = {8'h00, relay};
         CMD_QUERY:     result = rd_val;
         CMD_FW_VER:    result = FW_VER;
         CMD_HW_VER:    result = HW_VER;
         default:       result = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ENG_IDLE;
         cur   <= '0;
         cnt   <= '0;
         fb    <= '0;
         echo  <= '0;
      end else begin
         case (state)
            ENG_IDLE: if (start) begin
               cur   <= req;
               cnt   <= CNT_W'(LAT_CYC);
               state <= ENG_RUN;
            end
            ENG_RUN: begin
               if (done) begin
                  fb    <= result;
                  state <= ENG_ECHO;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ENG_ECHO: begin
               echo  <= cur.code;
               state <= ENG_IDLE;
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   // checker: cycles elapsed since the last accepted command
   logic [15:0] since;
   always_ff @(posedge clk) begin
      if (!rst_n)              since <= 16'hFFFF;
      else if (start && !busy) since <= '0;
      else if (since != 16'hFFFF) since <= since + 1'b1;
   end

   // R3: echo changes exactly LAT_CYC+2 edges after the command write
   p_echo_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (echo != $past(echo)) |-> (since == 16'(LAT_CYC + 2)));
   // R4: feedback is settled on the edge the echo moves
   p_fb_before_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (echo != $past(echo)) |-> (fb == $past(fb)));
   // R11: running command is not disturbed
   p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (cur == $past(cur)));
endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
   import mbx_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int OUT_OFS = 12,
   parameter int IN_OFS  = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              busy,
   output logic              start,
   output mbx_req_t          req,
   input  logic [15:0]       fb,
   input  logic [7:0]        echo,
   input  logic [7:0]        status
);
   localparam logic [ADDR_W-1:0] A_ARG_LO = ADDR_W'(OUT_OFS);
   localparam logic [ADDR_W-1:0] A_ARG_HI = ADDR_W'(OUT_OFS + 1);
   localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OUT_OFS + 2);
   localparam logic [ADDR_W-1:0] A_RSVD   = ADDR_W'(OUT_OFS + 3);
   localparam logic [ADDR_W-1:0] A_FB_LO  = ADDR_W'(IN_OFS);
   localparam logic [ADDR_W-1:0] A_FB_HI  = ADDR_W'(IN_OFS + 1);
   localparam logic [ADDR_W-1:0] A_ECHO   = ADDR_W'(IN_OFS + 2);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(IN_OFS + 3);

   logic [7:0] arg_lo, arg_hi, cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arg_lo <= '0;
         arg_hi <= '0;
         cmd_q  <= '0;
      end else if (bus_we) begin
         if (bus_addr == A_ARG_LO) arg_lo <= bus_wdata;
         if (bus_addr == A_ARG_HI) arg_hi <= bus_wdata;
         if (bus_addr == A_CMD)    cmd_q  <= bus_wdata;
      end
   end

   assign start = bus_we && (bus_addr == A_CMD) && !busy;
   assign req   = '{code: bus_wdata, arg: {arg_hi, arg_lo}};

   always_comb begin
      case (bus_addr)
         A_ARG_LO: bus_rdata = arg_lo;
         A_ARG_HI: bus_rdata = arg_hi;
         A_CMD:    bus_rdata = cmd_q;
         A_FB_LO:  bus_rdata = fb[7:0];
         A_FB_HI:  bus_rdata = fb[15:8];
         A_ECHO:   bus_rdata = echo;
         A_STAT:   bus_rdata = status;
         default:  bus_rdata = '0;
      endcase
   end

   // R2: reserved outgoing byte always reads zero
   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_RSVD) |-> (bus_rdata == 8'h00));
endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
   import mbx_pkg::*;
#(
   parameter int          ADDR_W       = 6,
   parameter int          LAT_CYC      = 64,
   parameter int          MAX_RESP_CYC = 12500,
   parameter int          REFRESH_CYC  = 5000,
   parameter int          SYNC_STAGES  = 2,
   parameter int          SET_BASE     = 16,
   parameter int          SET_COUNT    = 64,
   parameter logic [15:0] FW_VER       = 16'h0107,
   parameter logic [15:0] HW_VER       = 16'h0203
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        din_raw,
   output logic [7:0]        relay_o
);
   generate
      if (LAT_CYC + 2 > MAX_RESP_CYC) begin : g_chk_lat
         $error("response latency exceeds MAX_RESP_CYC");
      end
      if (REFRESH_CYC < 1 || SYNC_STAGES > REFRESH_CYC) begin : g_chk_ref
         $error("REFRESH_CYC must be at least 1 and at least SYNC_STAGES");
      end
      if (SET_BASE <= 15 || SET_BASE + SET_COUNT > 256) begin : g_chk_set
         $error("settings range must sit above 0x0F and below 0x100");
      end
      if ((1 << ADDR_W) < 32) begin : g_chk_addr
         $error("ADDR_W too small for the mailbox offsets");
      end
   endgenerate

   logic        busy, start;
   mbx_req_t    req;
   logic [15:0] fb;
   logic [7:0]  echo, status;
   logic        bank_we;
   logic [7:0]  bank_code, rd_code;
   logic [15:0] bank_val, rd_val;

   mbx_host_regs #(.ADDR_W(ADDR_W), .OUT_OFS(12), .IN_OFS(28)) u_host (
      .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
      .busy, .start, .req, .fb, .echo, .status
   );

   mbx_cmd_engine #(.LAT_CYC(LAT_CYC), .FW_VER(FW_VER), .HW_VER(HW_VER)) u_eng (
      .clk, .rst_n, .start, .req, .busy, .fb, .echo,
      .bank_we, .bank_code, .bank_val, .rd_code, .rd_val, .relay(relay_o)
   );

   mbx_setting_bank #(.SET_BASE(SET_BASE), .SET_COUNT(SET_COUNT)) u_bank (
      .clk, .rst_n, .wr_en(bank_we), .wr_code(bank_code), .wr_val(bank_val),
      .rd_code, .rd_val, .relay(relay_o)
   );

   mbx_input_sampler #(.REFRESH_CYC(REFRESH_CYC), .SYNC_STAGES(SYNC_STAGES), .WIDTH(8)) u_din (
      .clk, .rst_n, .din_raw, .status
   );
endmodule

// File: tb/mbx_responder_tb.sv
module mbx_responder_tb;
   localparam int LAT = 4;
   localparam int REF = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] din_raw = '0;
   logic [7:0] relay_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   mbx_responder #(.LAT_CYC(LAT), .REFRESH_CYC(REF), .FW_VER(16'h0107), .HW_VER(16'h0203)) u_dut (
      .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .din_raw, .relay_o
   );

   // entries: command, arg low, arg high, expected 16-bit feedback
   localparam int NV = 13;
   localparam logic [39:0] VEC [NV] = '{
      {8'h01, 8'hA5, 8'h00, 16'h0000},   // R6 set relays
      {8'h02, 8'h00, 8'h00, 16'h00A5},   // R6 read relays
      {8'h10, 8'h34, 8'h12, 16'h0000},   // R7 first setting
      {8'h4F, 8'hCD, 8'hAB, 16'h0000},   // R7 last setting
      {8'h03, 8'h10, 8'h00, 16'h1234},   // R7 query first
      {8'h03, 8'h4F, 8'h00, 16'hABCD},   // R7 query last (repeat command)
      {8'h03, 8'h01, 8'h00, 16'h00A5},   // R7 query relay
      {8'h03, 8'h20, 8'h00, 16'h0000},   // R7 never written setting
      {8'h03, 8'h05, 8'h00, 16'h0000},   // R7 code outside bank
      {8'h0E, 8'h00, 8'h00, 16'h0107},   // R8 firmware
      {8'h0F, 8'h00, 8'h00, 16'h0203},   // R8 hardware
      {8'h07, 8'h11, 8'h22, 16'h0000},   // R9 unknown
      {8'hC8, 8'h33, 8'h44, 16'h0000}    // R9 unknown high code
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_echo(input logic [7:0] c, input string req);
      logic [7:0] e;
      bit ok = 1'b0;
      for (int i = 0; i < 100; i++) begin
         rd(6'h1E, e);
         if (e == c) begin ok = 1'b1; break; end
         @(negedge clk);
      end
      if (!ok) check(req, {8'h00, e}, {8'h00, c});
   endtask

   task automatic issue(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi, input string req);
      logic [7:0] e;
      rd(6'h1E, e);
      if (e == c && c != 8'h00) begin
         wr(6'h0E, 8'h00);
         wait_echo(8'h00, "R5 clear before repeat");
      end
      wr(6'h0C, lo);
      wr(6'h0D, hi);
      wr(6'h0E, c);
      wait_echo(c, req);
   endtask

   task automatic read_fb(output logic [15:0] v);
      logic [7:0] l, h;
      rd(6'h1C, l);
      rd(6'h1D, h);
      v = {h, l};
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0]  b;
      logic [15:0] v;
      int          k;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      for (int a = 28; a < 32; a++) begin
         rd(6'(a), b);
         check("R1 incoming byte after reset", {8'h00, b}, 16'h0000);
      end
      for (int a = 12; a < 15; a++) begin
         rd(6'(a), b);
         check("R1 outgoing byte after reset", {8'h00, b}, 16'h0000);
      end
      check("R1 relays after reset", {8'h00, relay_o}, 16'h0000);

      // R2 readback and reserved byte
      wr(6'h0C, 8'h5A);
      wr(6'h0D, 8'hC3);
      wr(6'h0F, 8'hFF);
      rd(6'h0C, b); check("R2 arg low readback", {8'h00, b}, 16'h005A);
      rd(6'h0D, b); check("R2 arg high readback", {8'h00, b}, 16'h00C3);
      rd(6'h0F, b); check("R2 reserved reads zero", {8'h00, b}, 16'h0000);

      // vector table walk
      for (int i = 0; i < NV; i++) begin
         issue(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], "R3 table echo");
         read_fb(v);
         check($sformatf("R6-R9 table entry %0d", i), v, VEC[i][15:0]);
         if (VEC[i][39:32] == 8'h01)
            check("R6 relay pins", {8'h00, relay_o}, {8'h00, VEC[i][31:24]});
      end
      rd(6'h0E, b); check("R2 command readback", {8'h00, b}, 16'h00C8);

      // R3/R4 exact timing: command 0x0F after echo 0xC8
      wr(6'h0E, 8'h0F);
      for (k = 0; k <= LAT + 2; k++) begin
         if (k == LAT + 1) begin
            rd(6'h1E, b); check("R3 echo still old one edge early", {8'h00, b}, 16'h00C8);
            read_fb(v);   check("R4 feedback ready before echo", v, 16'h0203);
         end
         if (k == LAT + 2) begin
            rd(6'h1E, b); check("R3 echo at LAT+2", {8'h00, b}, 16'h000F);
         end
         if (k < LAT + 2) @(negedge clk);
      end

      // R5 clear
      wr(6'h0E, 8'h00);
      wait_echo(8'h00, "R5 clear echo");
      read_fb(v); check("R5 clear feedback", v, 16'h0000);

      // R11 writes during a running command
      wr(6'h0C, 8'h11);
      wr(6'h0D, 8'h22);
      wr(6'h0E, 8'h12);
      wr(6'h0E, 8'h01);   // ignored: busy
      wr(6'h0C, 8'hEE);   // must not alter running argument
      wait_echo(8'h12, "R11 running command kept");
      repeat (LAT + 4) @(negedge clk);
      rd(6'h1E, b); check("R11 second command dropped", {8'h00, b}, 16'h0012);
      check("R11 relays untouched", {8'h00, relay_o}, 16'h00A5);
      issue(8'h03, 8'h12, 8'h00, "R11 query");
      read_fb(v); check("R11 stored value from first argument", v, 16'h2211);

      // R10 input refresh
      din_raw = 8'h3C;
      k = 0;
      for (int i = 0; i < 3 * REF; i++) begin
         rd(6'h1F, b);
         if (b == 8'h3C) break;
         @(negedge clk);
         k++;
      end
      check("R10 status picks up inputs", {8'h00, b}, 16'h003C);
      check("R10 pickup within one period", {15'h0, (k <= REF + 3)}, 16'h0001);
      din_raw = 8'hC1;
      k = 0;
      for (int i = 0; i < 3 * REF; i++) begin
         @(negedge clk);
         k++;
         rd(6'h1F, b);
         if (b != 8'h3C) break;
      end
      check("R10 next refresh value", {8'h00, b}, 16'h00C1);
      check("R10 refresh period", 16'(k), 16'(REF));

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule